// File: doc/BRIEF.md
# Divide-by-Twelve Two-Section Counter

This block is a four-bit counter split into two sections. Bit 0 is a divide-by-two stage. Bits 3 to 1 form a divide-by-six stage. Each section has its own count input. A section steps only when its count input goes from high to low. Both count inputs are asynchronous to the system clock, so each one passes through a synchroniser, and its falling edge is found by comparing consecutive synchronised samples.

The `chain` input selects the mode:

- **Chained mode (`chain` = 1).** A falling edge of bit 0 advances the upper section internally, in the same system-clock cycle as the bit 0 change. The counter then runs as a modulo-12 counter. Bit 3 is a symmetric square wave at one twelfth of the input count rate.
- **Independent mode (`chain` = 0).** The two sections count on their own inputs. Bits 2 and 1 divide the upper count input by three, and bit 3 divides it by six.

A two-input AND-gated clear is synchronised to the system clock. It returns every bit to zero and blocks counting while it is held.

Top module: `mod12_split_counter`

## Requirements
- R1: When `clr_a` and `clr_b` are both high, `q` becomes 4'b0000 and stays there while both remain high.
- R2: With only one of `clr_a` or `clr_b` high, the clear has no effect and `q` keeps counting or holding as normal.
- R3: A falling edge on either count input that occurs while the clear is active is discarded. It does not advance `q` after the clear is released.
- R4: `q[0]` toggles on each high-to-low transition of `tick_a`. A low-to-high transition leaves `q` unchanged.
- R5: In independent mode, each falling edge of `tick_b` steps `q[3:1]` through 000, 001, 010, 100, 101, 110 and then back to 000. The codes 011 and 111 never appear.
- R6: In chained mode, falling edges of `tick_a` step `q` (bit 3 to bit 0) through 0000, 0001, 0010, 0011, 0100, 0101, 1000, 1001, 1010, 1011, 1100, 1101, and then wrap to 0000.
- R7: In chained mode, `q[3]` is low for six consecutive input counts and high for the following six.
- R8: In chained mode, `tick_b` has no effect on `q`.
- R9: A falling edge on a count input changes `q` on the third rising clock edge after the input changes. In chained mode, `q[3:1]` moves in the same cycle as the falling `q[0]` that drives it.
- R10: In independent mode, counting on either input leaves the other section's bits unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset of all state |
| tick_a | input | 1 | Count input of the divide-by-two section, asynchronous |
| tick_b | input | 1 | Count input of the divide-by-six section, asynchronous; ignored when chained |
| clr_a | input | 1 | Clear gate input A |
| clr_b | input | 1 | Clear gate input B |
| chain | input | 1 | 1: bit 0 feeds the upper section (modulo 12); 0: the sections are independent |
| q | output | 4 | Counter state, bit 3 to bit 0 |

## Verification
A count-input change appears on `q` on the third rising clock edge after the input changes: two edges in the synchroniser and one in the state register. The clear takes the same three edges.

Most checks allow slack for this latency. The bench changes an input on a falling clock edge, waits four clock periods, and then samples `q` on a falling edge. A dedicated check confirms the exact latency. It samples `q` after two rising edges and expects no change, then samples after the third and expects every bit to have moved together.

// File: rtl/mod12_split_counter.sv
module mod12_split_counter #(
  parameter int SYNC_DEPTH = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_a,
  input  logic       tick_b,
  input  logic       clr_a,
  input  logic       clr_b,
  input  logic       chain,
  output logic [3:0] q
);
  localparam int TOP = SYNC_DEPTH - 1;

  logic [TOP:0] sync_a, sync_b, sync_c;
  logic         last_a, last_b;
  logic         clr_s, fall_a, fall_b, adv_lo, adv_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_a <= '0;
      sync_b <= '0;
      sync_c <= '0;
      last_a <= 1'b0;
      last_b <= 1'b0;
    end else begin
      sync_a <= {sync_a[TOP-1:0], tick_a};
      sync_b <= {sync_b[TOP-1:0], tick_b};
      sync_c <= {sync_c[TOP-1:0], clr_a & clr_b};
      last_a <= sync_a[TOP];
      last_b <= sync_b[TOP];
    end
  end

  assign clr_s  = sync_c[TOP];
  assign fall_a = last_a & ~sync_a[TOP];
  assign fall_b = last_b & ~sync_b[TOP];
  assign adv_lo = fall_a & ~clr_s;
  assign adv_hi = ~clr_s & (chain ? (fall_a & q[0]) : fall_b);

  function automatic logic [2:0] step6(input logic [2:0] s);
    case (s[1:0])
      2'b00:   return {s[2], 2'b01};
      2'b01:   return {s[2], 2'b10};
      2'b10:   return {~s[2], 2'b00};
      default: return 3'b000;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      q <= 4'b0000;
    else if (clr_s)
      q <= 4'b0000;
    else begin
      if (adv_lo) q[0]   <= ~q[0];
      if (adv_hi) q[3:1] <= step6(q[3:1]);
    end
  end
endmodule

module mod12_split_counter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       chain,
  input logic [3:0] q,
  input logic       clr_s,
  input logic       fall_a
);
  assert_clear_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    clr_s |=> (q == 4'b0000));

  assert_q0_only_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!fall_a && !clr_s) |=> $stable(q[0]));

  assert_no_unused_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (q[2:1] != 2'b11));

  assert_q3_rise_point_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (chain && !clr_s && !q[3]) |=> (!q[3] || $past(q[2:0]) == 3'b101));

  assert_chain_follows_q0_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (chain && !clr_s && !(fall_a && q[0])) |=> $stable(q[3:1]));
endmodule

bind mod12_split_counter mod12_split_counter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .chain(chain), .q(q), .clr_s(clr_s), .fall_a(fall_a)
);

// File: tb/mod12_split_counter_tb.sv
module mod12_split_counter_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_a = 1'b0, tick_b = 1'b0, clr_a = 1'b0, clr_b = 1'b0, chain = 1'b0;
  logic [3:0] q;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mod12_split_counter u_dut (
    .clk(clk), .rst_n(rst_n), .tick_a(tick_a), .tick_b(tick_b),
    .clr_a(clr_a), .clr_b(clr_b), .chain(chain), .q(q)
  );

  function automatic logic [2:0] hi6(input int k);
    int lo = k % 3;
    return {logic'((k % 6) >= 3), logic'(lo == 2), logic'(lo == 1)};
  endfunction

  function automatic logic [3:0] mod12(input int n);
    return {hi6((n % 12) / 2), logic'(n % 2)};
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic [3:0] exp, input string tag);
    n_chk++;
    if (q !== exp) begin
      n_bad++;
      $display("FAIL %s: q=%b expected %b", tag, q, exp);
    end
  endtask

  task automatic pulse_a();
    tick_a = 1'b1; step(4);
    tick_a = 1'b0; step(4);
  endtask

  task automatic pulse_b();
    tick_b = 1'b1; step(4);
    tick_b = 1'b0; step(4);
  endtask

  task automatic do_clear();
    clr_a = 1'b1; clr_b = 1'b1; step(4);
    clr_a = 1'b0; clr_b = 1'b0; step(4);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(2);
    chk(4'b0000, "R1 reset state");

    chain = 1'b0;
    for (int i = 1; i <= 13; i++) begin
      pulse_b();
      chk({hi6(i), 1'b0}, "R5 R10 independent div6");
    end
    for (int i = 1; i <= 3; i++) begin
      pulse_a();
      chk({hi6(13), logic'(i % 2)}, "R4 R10 independent div2");
    end

    clr_a = 1'b1; step(6);
    chk({hi6(13), 1'b1}, "R2 clr_a alone");
    clr_a = 1'b0; clr_b = 1'b1; step(2);
    pulse_a();
    chk({hi6(13), 1'b0}, "R2 clr_b alone, counting continues");
    clr_b = 1'b0; step(2);

    clr_a = 1'b1; clr_b = 1'b1; step(4);
    chk(4'b0000, "R1 clear forces zero");
    pulse_a(); pulse_b();
    chk(4'b0000, "R1 R3 held during clear");
    tick_a = 1'b1; tick_b = 1'b1; step(4);
    tick_a = 1'b0; tick_b = 1'b0; step(1);
    clr_a = 1'b0; clr_b = 1'b0; step(8);
    chk(4'b0000, "R3 edges during clear discarded");

    tick_a = 1'b1; step(5);
    chk(4'b0000, "R4 rising edge no effect");
    tick_a = 1'b0; step(4);
    chk(4'b0001, "R4 falling edge toggles");
    do_clear();

    chain = 1'b1;
    for (int n = 1; n <= 26; n++) begin
      pulse_a();
      chk(mod12(n), "R6 chained sequence");
      n_chk++;
      if (q[3] !== logic'((n % 12) >= 6)) begin
        n_bad++;
        $display("FAIL R7: n=%0d q3=%b expected %b", n, q[3], (n % 12) >= 6);
      end
    end
    for (int i = 0; i < 3; i++) pulse_b();
    chk(mod12(26), "R8 tick_b ignored when chained");

    pulse_a();
    chk(4'b0011, "R9 setup");
    tick_a = 1'b1; step(4);
    tick_a = 1'b0; step(2);
    chk(4'b0011, "R9 unchanged after two edges");
    step(1);
    chk(4'b0100, "R9 all bits move on third edge");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule